// File: doc/BRIEF.md
# Time-Shared Gram-Schmidt Projection Update

This block performs one orthogonalisation step of a modified Gram-Schmidt decomposition on complex columns of eight elements. A column pair arrives as a stream, one element per clock: a unit-direction vector `u` and a working column `v`. While the pair streams in, the block accumulates the conjugate inner product r = sum of conj(u_k)·v_k and, on a separate path, the squared Euclidean norm of `v`. Once the eighth element has been taken, r and the norm are presented for one cycle, and the updated column v_k − r·u_k streams out in element order.

Each multiplier serves all eight elements of a column, so the time-sharing order is eight and a new column pair may start every eight clocks, back to back. The inner product and the projection each use a complex multiplier built from three real multipliers, six in total, and the norm path uses two squarers. The `u` and `v` elements are parked in an eight-entry store until r is final. The next pair may overwrite an entry in the same cycle the stored value is read out. Operands are signed fixed point with `FRAC` fractional bits.

Top module: `gsUpdate`

## Requirements
- R1: While `rstN` is low and on the first cycle after its release, `rValid`, `normValid`, `updValid` and `updSoc` are low.
- R2: After an element with index 7 is taken, `rValid` is high for exactly the next cycle, with `rRe`/`rIm` holding sat_W(sum over k of P(conj(u_k), v_k)), where the sum is carried without overflow.
- R3: A complex product P(a, b) is formed exactly, then each part is rounded as floor((x + 2^(FRAC−1)) / 2^FRAC), so halves round upward, and saturated to the signed W-bit range.
- R4: The inner-product accumulator holds eight saturated W-bit terms with no wrap; only the final sum is saturated to W bits, to 2^(W−1)−1 or −2^(W−1).
- R5: In the same cycle as `rValid`, `normValid` is high and `normSq` equals the sum over k of floor((vRe_k² + vIm_k² + 2^(FRAC−1)) / 2^FRAC), unsigned and unsaturated.
- R6: Updated element k equals sat_W(v_k − P(r, u_k)) per part, and appears k+2 cycles after the cycle that carried element 7; elements leave in index order 0 to 7.
- R7: `updValid` is high for exactly eight consecutive cycles per completed column; `updSoc` is high only with element 0, and every rise of `updValid` carries `updSoc`.
- R8: A new column may begin in the cycle right after element 7 of the previous one; both columns complete with their own r, norm and updated elements.
- R9: The element index is 0 after reset, becomes 0 on any taken element with `inSoc` high, and otherwise advances by one per taken element, wrapping after 7; a column cut short by a new `inSoc` produces no result.
- R10: Cycles with `inValid` low, including gaps inside a column, change no result, whatever `inSoc`, `uRe`, `uIm`, `vRe` and `vIm` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Element present on the inputs this cycle |
| inSoc | input | 1 | Element is index 0 of a new column |
| uRe | input | W | Real part of u element, signed |
| uIm | input | W | Imaginary part of u element, signed |
| vRe | input | W | Real part of v element, signed |
| vIm | input | W | Imaginary part of v element, signed |
| rValid | output | 1 | Inner product valid, one cycle |
| rRe | output | W | Inner product, real part |
| rIm | output | W | Inner product, imaginary part |
| normValid | output | 1 | Squared norm valid, one cycle |
| normSq | output | NORM_W | Squared norm of the v column, unsigned |
| updValid | output | 1 | Updated element valid |
| updSoc | output | 1 | Updated element is index 0 |
| updRe | output | W | Updated element, real part |
| updIm | output | W | Updated element, imaginary part |

## Verification
Every result is timed from the cycle that carries element 7 of a column: r and the norm are due one cycle later, and updated element k is due k+2 cycles later. For a gap-free column this is nine cycles after element k entered. The bench drives each input before a rising edge and samples at the following falling edge. Its reference model schedules each expected value into a per-cycle table at exactly these offsets, and on every cycle it compares all four strobes, plus the data of any strobe that is due. Gaps inside a column, restarts, back-to-back columns and saturating operands shift these due cycles in the model only through the position of element 7.

// File: rtl/gsPkg.sv
package gsPkg;

  // Column length; the time-sharing order of every multiplier equals it.
  parameter int unsigned COL_LEN = 8;
  localparam int unsigned IDX_W = $clog2(COL_LEN);

  // Strobes passed from the control to the datapath.
  typedef struct packed {
    logic             take;     // element accepted this cycle
    logic             first;    // accepted element is index 0
    logic             last;     // accepted element closes the column
    logic [IDX_W-1:0] wrIdx;    // store slot for the accepted element
    logic             rdEn;     // projection pass active
    logic             rdFirst;  // projection pass at index 0
    logic [IDX_W-1:0] rdIdx;    // store slot being projected
  } gsCtrl_t;

endpackage

// File: rtl/gsCmul.sv
// Complex product from three real multipliers; optional conjugate of operand a.
// Each part is rounded half-up at FRAC and saturated to W bits.
module gsCmul #(
  parameter int W    = 16,
  parameter int FRAC = 14
) (
  input  logic                conjA,
  input  logic signed [W-1:0] aRe,
  input  logic signed [W-1:0] aIm,
  input  logic signed [W-1:0] bRe,
  input  logic signed [W-1:0] bIm,
  output logic signed [W-1:0] pRe,
  output logic signed [W-1:0] pIm
);

  localparam int PW = 2 * W + 4;
  localparam logic signed [PW-1:0] HALF   = PW'(2 ** (FRAC - 1));
  localparam logic signed [PW-1:0] MAX_PW = {{(PW - W + 1){1'b0}}, {(W - 1){1'b1}}};
  localparam logic signed [PW-1:0] MIN_PW = ~MAX_PW;

  logic signed [W:0]    opA, opB, opC, opD;
  logic signed [W+1:0]  sumAB, difDC, sumCD;
  logic signed [PW-1:0] k1, k2, k3, exRe, exIm;

  function automatic logic signed [W-1:0] roundSat(input logic signed [PW-1:0] x);
    logic signed [PW-1:0] t;
    t = (x + HALF) >>> FRAC;
    if (t > MAX_PW)      roundSat = {1'b0, {(W - 1){1'b1}}};
    else if (t < MIN_PW) roundSat = {1'b1, {(W - 1){1'b0}}};
    else                 roundSat = t[W-1:0];
  endfunction

  assign opA = {aRe[W-1], aRe};
  assign opB = conjA ? -{aIm[W-1], aIm} : {aIm[W-1], aIm};
  assign opC = {bRe[W-1], bRe};
  assign opD = {bIm[W-1], bIm};

  assign sumAB = {opA[W], opA} + {opB[W], opB};
  assign difDC = {opD[W], opD} - {opC[W], opC};
  assign sumCD = {opC[W], opC} + {opD[W], opD};

  assign k1 = PW'(opC) * PW'(sumAB);
  assign k2 = PW'(opA) * PW'(difDC);
  assign k3 = PW'(opB) * PW'(sumCD);

  assign exRe = k1 - k3;
  assign exIm = k1 + k2;

  assign pRe = roundSat(exRe);
  assign pIm = roundSat(exIm);

endmodule

// File: rtl/gsCtrl.sv
// Element indexing and projection-pass sequencing.
module gsCtrl
  import gsPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    inSoc,
  output gsCtrl_t ctl
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(COL_LEN - 1);

  logic [IDX_W-1:0] idxCnt, curIdx, rdIdx;
  logic             rdActive, isLast;

  assign curIdx = inSoc ? '0 : idxCnt;
  assign isLast = inValid && (curIdx == LAST_IDX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxCnt <= '0;
    end else if (inValid) begin
      idxCnt <= (curIdx == LAST_IDX) ? '0 : curIdx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdActive <= 1'b0;
      rdIdx    <= '0;
    end else if (isLast) begin
      rdActive <= 1'b1;
      rdIdx    <= '0;
    end else if (rdActive) begin
      if (rdIdx == LAST_IDX) rdActive <= 1'b0;
      else                   rdIdx    <= rdIdx + 1'b1;
    end
  end

  always_comb begin
    ctl.take    = inValid;
    ctl.first   = inValid && (curIdx == '0);
    ctl.last    = isLast;
    ctl.wrIdx   = curIdx;
    ctl.rdEn    = rdActive;
    ctl.rdFirst = rdActive && (rdIdx == '0);
    ctl.rdIdx   = rdIdx;
  end

  // A closed column always launches the projection pass at index 0.
  assert_pass_start_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.last |=> (ctl.rdEn && ctl.rdFirst));

  // Two columns cannot close on adjacent cycles.
  assert_last_spacing_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.last |=> !ctl.last);

endmodule

// File: rtl/gsData.sv
// Inner-product and norm accumulation, element store, projection update.
module gsData
  import gsPkg::*;
#(
  parameter int W      = 16,
  parameter int FRAC   = 14,
  parameter int NORM_W = 2 * W + 2 - FRAC + IDX_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  gsCtrl_t             ctl,
  input  logic signed [W-1:0] uRe,
  input  logic signed [W-1:0] uIm,
  input  logic signed [W-1:0] vRe,
  input  logic signed [W-1:0] vIm,
  output logic                rValid,
  output logic signed [W-1:0] rRe,
  output logic signed [W-1:0] rIm,
  output logic                normValid,
  output logic [NORM_W-1:0]   normSq,
  output logic                updValid,
  output logic                updSoc,
  output logic signed [W-1:0] updRe,
  output logic signed [W-1:0] updIm
);

  localparam int ACC_W = W + IDX_W;
  localparam int SQ_W  = 2 * W + 1;
  localparam logic signed [ACC_W-1:0] ACC_MAX = {{(ACC_W - W + 1){1'b0}}, {(W - 1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = ~ACC_MAX;
  localparam logic signed [W:0]       DIF_MAX = {2'b00, {(W - 1){1'b1}}};
  localparam logic signed [W:0]       DIF_MIN = ~DIF_MAX;
  localparam logic signed [SQ_W-1:0]  SQ_HALF = SQ_W'(2 ** (FRAC - 1));

  function automatic logic signed [W-1:0] satAcc(input logic signed [ACC_W-1:0] x);
    if (x > ACC_MAX)      satAcc = {1'b0, {(W - 1){1'b1}}};
    else if (x < ACC_MIN) satAcc = {1'b1, {(W - 1){1'b0}}};
    else                  satAcc = x[W-1:0];
  endfunction

  function automatic logic signed [W-1:0] satDif(input logic signed [W:0] x);
    if (x > DIF_MAX)      satDif = {1'b0, {(W - 1){1'b1}}};
    else if (x < DIF_MIN) satDif = {1'b1, {(W - 1){1'b0}}};
    else                  satDif = x[W-1:0];
  endfunction

  // ---------------- inner product r = sum conj(u_k) v_k ----------------
  logic signed [W-1:0]     termRe, termIm;
  logic signed [ACC_W-1:0] accRe, accIm, nextAccRe, nextAccIm;

  gsCmul #(.W(W), .FRAC(FRAC)) u_dotMul (
    .conjA (1'b1),
    .aRe   (uRe),
    .aIm   (uIm),
    .bRe   (vRe),
    .bIm   (vIm),
    .pRe   (termRe),
    .pIm   (termIm)
  );

  assign nextAccRe = (ctl.first ? '0 : accRe) + ACC_W'(termRe);
  assign nextAccIm = (ctl.first ? '0 : accIm) + ACC_W'(termIm);

  // ---------------- squared norm of v ----------------
  logic signed [2*W-1:0]  sqRe, sqIm;
  logic signed [SQ_W-1:0] sqSum, sqRnd;
  logic [NORM_W-1:0]      normAcc, nextNorm;

  assign sqRe     = (2*W)'(vRe) * (2*W)'(vRe);
  assign sqIm     = (2*W)'(vIm) * (2*W)'(vIm);
  assign sqSum    = {sqRe[2*W-1], sqRe} + {sqIm[2*W-1], sqIm};
  assign sqRnd    = (sqSum + SQ_HALF) >>> FRAC;
  assign nextNorm = (ctl.first ? '0 : normAcc) + sqRnd[NORM_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accRe     <= '0;
      accIm     <= '0;
      normAcc   <= '0;
      rValid    <= 1'b0;
      normValid <= 1'b0;
      rRe       <= '0;
      rIm       <= '0;
      normSq    <= '0;
    end else begin
      rValid    <= ctl.last;
      normValid <= ctl.last;
      if (ctl.take) begin
        accRe   <= nextAccRe;
        accIm   <= nextAccIm;
        normAcc <= nextNorm;
      end
      if (ctl.last) begin
        rRe    <= satAcc(nextAccRe);
        rIm    <= satAcc(nextAccIm);
        normSq <= nextNorm;
      end
    end
  end

  // ---------------- element store ----------------
  logic signed [W-1:0] uStRe [COL_LEN];
  logic signed [W-1:0] uStIm [COL_LEN];
  logic signed [W-1:0] vStRe [COL_LEN];
  logic signed [W-1:0] vStIm [COL_LEN];

  always_ff @(posedge clk) begin
    for (int e = 0; e < COL_LEN; e++) begin
      if (ctl.take && (ctl.wrIdx == IDX_W'(e))) begin
        uStRe[e] <= uRe;
        uStIm[e] <= uIm;
        vStRe[e] <= vRe;
        vStIm[e] <= vIm;
      end
    end
  end

  // ---------------- projection update v_k - r u_k ----------------
  logic signed [W-1:0] projRe, projIm;
  logic signed [W:0]   difRe, difIm;

  gsCmul #(.W(W), .FRAC(FRAC)) u_projMul (
    .conjA (1'b0),
    .aRe   (rRe),
    .aIm   (rIm),
    .bRe   (uStRe[ctl.rdIdx]),
    .bIm   (uStIm[ctl.rdIdx]),
    .pRe   (projRe),
    .pIm   (projIm)
  );

  assign difRe = {vStRe[ctl.rdIdx][W-1], vStRe[ctl.rdIdx]} - {projRe[W-1], projRe};
  assign difIm = {vStIm[ctl.rdIdx][W-1], vStIm[ctl.rdIdx]} - {projIm[W-1], projIm};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      updValid <= 1'b0;
      updSoc   <= 1'b0;
      updRe    <= '0;
      updIm    <= '0;
    end else begin
      updValid <= ctl.rdEn;
      updSoc   <= ctl.rdFirst;
      if (ctl.rdEn) begin
        updRe <= satDif(difRe);
        updIm <= satDif(difIm);
      end
    end
  end

  // ---------------- checks beside the logic ----------------
  assert_soc_with_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    updSoc |-> updValid);

  assert_rise_carries_soc_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(updValid) |-> updSoc);

  assert_update_follows_r_R6: assert property (@(posedge clk) disable iff (!rstN)
    rValid |=> (updValid && updSoc));

  assert_norm_then_update_R5: assert property (@(posedge clk) disable iff (!rstN)
    normValid |=> updSoc);

endmodule

// File: rtl/gsUpdate.sv
// Top: one Gram-Schmidt projection step on streamed 8-element complex columns.
module gsUpdate
  import gsPkg::*;
#(
  parameter  int W      = 16,
  parameter  int FRAC   = 14,
  localparam int NORM_W = 2 * W + 2 - FRAC + IDX_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic                inSoc,
  input  logic signed [W-1:0] uRe,
  input  logic signed [W-1:0] uIm,
  input  logic signed [W-1:0] vRe,
  input  logic signed [W-1:0] vIm,
  output logic                rValid,
  output logic signed [W-1:0] rRe,
  output logic signed [W-1:0] rIm,
  output logic                normValid,
  output logic [NORM_W-1:0]   normSq,
  output logic                updValid,
  output logic                updSoc,
  output logic signed [W-1:0] updRe,
  output logic signed [W-1:0] updIm
);

  gsCtrl_t ctl;

  gsCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inSoc   (inSoc),
    .ctl     (ctl)
  );

  gsData #(.W(W), .FRAC(FRAC), .NORM_W(NORM_W)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .uRe       (uRe),
    .uIm       (uIm),
    .vRe       (vRe),
    .vIm       (vIm),
    .rValid    (rValid),
    .rRe       (rRe),
    .rIm       (rIm),
    .normValid (normValid),
    .normSq    (normSq),
    .updValid  (updValid),
    .updSoc    (updSoc),
    .updRe     (updRe),
    .updIm     (updIm)
  );

endmodule

// File: tb/gsUpdate_tb.sv
module gsUpdate_tb;

  localparam int PERIOD = 10;
  localparam int W      = 16;
  localparam int FRAC   = 14;
  localparam int NW     = 2 * W + 2 - FRAC + 3;
  localparam int MAXS   = 512;
  localparam int TAIL   = 16;
  localparam int MAXT   = MAXS + TAIL;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inSoc = 1'b0;
  logic signed [W-1:0] uRe = '0, uIm = '0, vRe = '0, vIm = '0;
  logic rValid, normValid, updValid, updSoc;
  logic signed [W-1:0] rRe, rIm, updRe, updIm;
  logic [NW-1:0] normSq;

  always #(PERIOD / 2) clk = ~clk;

  gsUpdate #(.W(W), .FRAC(FRAC)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSoc(inSoc),
    .uRe(uRe), .uIm(uIm), .vRe(vRe), .vIm(vIm),
    .rValid(rValid), .rRe(rRe), .rIm(rIm),
    .normValid(normValid), .normSq(normSq),
    .updValid(updValid), .updSoc(updSoc), .updRe(updRe), .updIm(updIm)
  );

  int checks = 0;
  int errors = 0;
  int seed = 7;

  // stimulus, one entry per cycle
  bit     sV [MAXS];
  bit     sS [MAXS];
  longint sUr [MAXS], sUi [MAXS], sVr [MAXS], sVi [MAXS];
  string  sTag [MAXS];
  int     nS = 0;

  // expectations, indexed by the sampling cycle
  bit     eRV [MAXT];
  longint eRr [MAXT], eRi [MAXT], eNorm [MAXT];
  bit     eUV [MAXT], eUS [MAXT];
  longint eUr [MAXT], eUi [MAXT];
  string  eTag [MAXT];

  function automatic longint sat(longint x);
    longint hi = (64'sd1 <<< (W - 1)) - 1;
    if (x > hi) return hi;
    if (x < -hi - 1) return -hi - 1;
    return x;
  endfunction

  function automatic longint rnd(longint x);
    return (x + (64'sd1 <<< (FRAC - 1))) >>> FRAC;
  endfunction

  function int nextVal(int span);
    seed = seed * 1103515245 + 12345;
    return ((seed >>> 8) & 32'h7fff) % (2 * span + 1) - span;
  endfunction

  task automatic addStep(bit v, bit s, longint ur, longint ui, longint vr, longint vi, string tag);
    sV[nS] = v; sS[nS] = s; sUr[nS] = ur; sUi[nS] = ui; sVr[nS] = vr; sVi[nS] = vi;
    sTag[nS] = tag; nS++;
  endtask

  // idle cycles carry junk to show it is ignored (R10)
  task automatic addIdle(int n, string tag);
    for (int i = 0; i < n; i++)
      addStep(1'b0, i[0], nextVal(30000), nextVal(30000), nextVal(30000), nextVal(30000), tag);
  endtask

  // mode 0: random, 1: large positive, 2: mixed extremes, 3: rounding halves
  task automatic addElem(int k, int mode, bit soc, string tag);
    case (mode)
      1: addStep(1'b1, soc, 32767, 0, 32767, 0, tag);
      2: addStep(1'b1, soc, k[0] ? -32768 : 32767, -32768, k[1] ? 32767 : -32768, 32767, tag);
      3: addStep(1'b1, soc, 8192, 0, k[0] ? -(2 * k + 1) : (2 * k + 1), 1, tag);
      default: addStep(1'b1, soc, nextVal(16384), nextVal(16384), nextVal(16384), nextVal(16384), tag);
    endcase
  endtask

  task automatic addCol(int mode, string tag);
    for (int k = 0; k < 8; k++) addElem(k, mode, k == 0, tag);
  endtask

  // behavioural reference: walks the stimulus and fills the due-cycle table
  task automatic buildModel();
    longint cu [8][2];
    longint cv [8][2];
    int idx = 0;
    for (int t = 0; t < MAXT; t++) begin
      eRV[t] = 0; eUV[t] = 0; eUS[t] = 0; eTag[t] = "";
    end
    for (int n = 0; n < nS; n++) begin
      if (sV[n]) begin
        int i = sS[n] ? 0 : idx;
        cu[i][0] = sUr[n]; cu[i][1] = sUi[n];
        cv[i][0] = sVr[n]; cv[i][1] = sVi[n];
        idx = (i + 1) % 8;
        if (i == 7) begin
          longint ar = 0, ai = 0, nr = 0, r0, r1;
          for (int k = 0; k < 8; k++) begin
            ar += sat(rnd(cu[k][0] * cv[k][0] + cu[k][1] * cv[k][1]));
            ai += sat(rnd(cu[k][0] * cv[k][1] - cu[k][1] * cv[k][0]));
            nr += rnd(cv[k][0] * cv[k][0] + cv[k][1] * cv[k][1]);
          end
          r0 = sat(ar); r1 = sat(ai);
          eRV[n + 1] = 1; eRr[n + 1] = r0; eRi[n + 1] = r1; eNorm[n + 1] = nr;
          eTag[n + 1] = sTag[n];
          for (int k = 0; k < 8; k++) begin
            longint pr = sat(rnd(r0 * cu[k][0] - r1 * cu[k][1]));
            longint pi = sat(rnd(r0 * cu[k][1] + r1 * cu[k][0]));
            eUV[n + 2 + k] = 1; eUS[n + 2 + k] = (k == 0);
            eUr[n + 2 + k] = sat(cv[k][0] - pr);
            eUi[n + 2 + k] = sat(cv[k][1] - pi);
            eTag[n + 2 + k] = sTag[n];
          end
        end
      end
    end
  endtask

  task automatic check(bit ok, string req, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] %s: actual %0d expected %0d", req, tag, what, act, exp);
    end
  endtask

  task automatic compareCycle(int t);
    check(rValid == eRV[t], "R2", eTag[t], "rValid", longint'(rValid), longint'(eRV[t]));
    check(normValid == eRV[t], "R5", eTag[t], "normValid", longint'(normValid), longint'(eRV[t]));
    check(updValid == eUV[t], "R7", eTag[t], "updValid", longint'(updValid), longint'(eUV[t]));
    check(updSoc == eUS[t], "R7", eTag[t], "updSoc", longint'(updSoc), longint'(eUS[t]));
    if (eRV[t]) begin
      check(longint'(rRe) == eRr[t], "R2", eTag[t], "rRe", longint'(rRe), eRr[t]);
      check(longint'(rIm) == eRi[t], "R2", eTag[t], "rIm", longint'(rIm), eRi[t]);
      check(longint'(normSq) == eNorm[t], "R5", eTag[t], "normSq", longint'(normSq), eNorm[t]);
    end
    if (eUV[t]) begin
      check(longint'(updRe) == eUr[t], "R6", eTag[t], "updRe", longint'(updRe), eUr[t]);
      check(longint'(updIm) == eUi[t], "R6", eTag[t], "updIm", longint'(updIm), eUi[t]);
    end
  endtask

  initial begin
    // scenario list
    addIdle(3, "R10");
    addCol(0, "R2");
    addIdle(4, "R10");
    addCol(3, "R3");              // half-LSB ties round upward
    addIdle(2, "R10");
    addCol(1, "R4");              // accumulator beyond W bits, r saturates high
    addIdle(1, "R10");
    addCol(2, "R4");              // extreme signs, saturation both ways
    addIdle(3, "R10");
    addCol(0, "R8");              // three columns with no gap
    addCol(0, "R8");
    addCol(2, "R8");
    addIdle(5, "R10");
    for (int k = 0; k < 3; k++) addElem(k, 0, k == 0, "R9");
    addCol(0, "R9");              // restart abandons the partial column
    addIdle(2, "R10");
    for (int k = 0; k < 5; k++) addElem(k, 0, k == 0, "R9");
    for (int k = 0; k < 8; k++) addElem(k, 0, k == 0, "R9");
    addIdle(10, "R10");
    for (int k = 0; k < 8; k++) begin   // gaps inside a column
      addElem(k, 0, k == 0, "R10");
      if (k == 2 || k == 5) addIdle(2, "R10");
    end
    addIdle(1, "R10");
    addCol(0, "R5");
    addCol(0, "R6");
    addIdle(2, "R10");
    buildModel();

    // reset state (R1)
    repeat (3) @(negedge clk);
    check(!rValid, "R1", "R1", "rValid in reset", longint'(rValid), 0);
    check(!normValid, "R1", "R1", "normValid in reset", longint'(normValid), 0);
    check(!updValid, "R1", "R1", "updValid in reset", longint'(updValid), 0);
    check(!updSoc, "R1", "R1", "updSoc in reset", longint'(updSoc), 0);
    rstN = 1'b1;

    for (int n = 0; n < nS + TAIL; n++) begin
      @(negedge clk);
      compareCycle(n);
      if (n < nS) begin
        inValid = sV[n]; inSoc = sS[n];
        uRe = W'(sUr[n]); uIm = W'(sUi[n]); vRe = W'(sVr[n]); vIm = W'(sVi[n]);
      end else begin
        inValid = 1'b0; inSoc = 1'b0;
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule